// File: doc/BRIEF.md
# Edge-Triggered LED Pulse Stretcher

This block turns any event on a digital input, from a single-cycle glitch to a level that is held for seconds, into one pulse on an LED output. The pulse always lasts half a second. The block computes the pulse length in clock cycles from a clock-frequency parameter, so the visible on-time does not change when the block is reused at a different clock rate.

A parameter chooses the input edge that starts the pulse: the low-to-high transition or the high-to-low one. The input may be asynchronous to the clock, so it passes through a flop-chain synchroniser before edge detection. This chain adds a small fixed latency.

While a pulse is running, further edges of the chosen kind are dropped. The timer is not restarted. The first qualifying edge after the pulse ends starts a new full pulse.

Top module: `evt_led_stretch`

## Requirements
- R1: Each pulse keeps `led_o` high for exactly `CLK_HZ/2` consecutive clock cycles (integer division), after which `led_o` returns low.
- R2: With `TRIG_EDGE = EDGE_RISE` (encoding 0), a 0-to-1 transition of `evt_i` starts a pulse and a 1-to-0 transition starts none.
- R3: With `TRIG_EDGE = EDGE_FALL` (encoding 1), a 1-to-0 transition of `evt_i` starts a pulse and a 0-to-1 transition starts none.
- R4: The pulse length does not depend on how long `evt_i` stays at its new level, from one clock cycle up to longer than the pulse itself.
- R5: With `SYNC_STAGES = 2`, `led_o` is first seen high after the third rising clock edge that follows the qualifying change of `evt_i`. In general this is edge `SYNC_STAGES + 1`.
- R6: A qualifying edge that reaches the timer while `led_o` is high, including on the last high cycle, is ignored. It neither restarts nor extends the pulse.
- R7: While `rst_i` (active high, synchronous) is asserted, `led_o` is low and the timer is cleared. A pulse in progress is abandoned and does not resume after reset.
- R8: A qualifying edge that reaches the timer in the first cycle after `led_o` has gone low starts a new full-length pulse, leaving a one-cycle low gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, frequency given by `CLK_HZ` |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event input, may be asynchronous to `clk_i` |
| led_o | output | 1 | Stretched pulse to the LED driver |

## Verification
The assertions assume that `evt_i` sits low while `rst_i` is asserted. The synchroniser and the edge history are cleared to 0, so a high input at reset release would count as a low-to-high transition. Every stimulus sequence in the bench returns the input low before it ends, and reset is applied only while the input is low.

The assertions also assume that the synchronised level reaching the edge picker is free of X. The bench drives `evt_i` only from procedural code on the falling clock edge, so the level is always defined and changes away from the sampling edge.

A small `CLK_HZ` keeps every pulse a few cycles long. This lets the bench sweep every input width from one cycle to past the pulse length on both edge modes.

// File: rtl/evt_led_pkg.sv
package evt_led_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   // cycles in half a second of the given clock
   function automatic int unsigned half_sec_cycles(input int unsigned hz);
      return hz / 2;
   endfunction

   // counter width able to hold values 0 .. n-1, never below one bit
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/evt_sync_chain.sv
module evt_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[0] <= 1'b0;
            else       chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[s] <= 1'b0;
            else       chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/evt_edge_pick.sv
module evt_edge_pick
   import evt_led_pkg::*;
#(
   parameter edge_sel_e EDGE = EDGE_RISE
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   output logic trig_o
);

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= lvl_i;
   end

   if (EDGE == EDGE_RISE) begin : g_rise
      assign trig_o = lvl_i & ~prev_q;

      // a rising trigger leaves the history high one cycle later
      assert_rise_hist_R2: assert property (@(posedge clk_i) disable iff (rst_i)
         trig_o |=> prev_q);
   end else begin : g_fall
      assign trig_o = ~lvl_i & prev_q;

      // a falling trigger leaves the history low one cycle later
      assert_fall_hist_R3: assert property (@(posedge clk_i) disable iff (rst_i)
         trig_o |=> !prev_q);
   end

   // two triggers never arrive on consecutive cycles
   assert_no_double_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      trig_o |=> !trig_o);

endmodule

// File: rtl/evt_hold_timer.sv
module evt_hold_timer #(
   parameter int unsigned CYCLES = 10,
   parameter int unsigned CNT_W  = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic trig_i,
   output logic busy_o
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("evt_hold_timer: CYCLES must be at least 1");
   end
   if ((CYCLES > 1) && ((64'd1 << CNT_W) < 64'(CYCLES))) begin : g_bad_width
      $error("evt_hold_timer: CNT_W too narrow for CYCLES");
   end

   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             last_c;

   assign last_c = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         if (trig_i) begin
            cnt_q  <= LOAD_VAL;
            busy_q <= 1'b1;
         end
      end else if (last_c) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;

   assert_start_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (trig_i && !busy_q) |=> busy_q);

   assert_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && !last_c) |=> busy_q);

   assert_end_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && last_c) |=> !busy_q);

   assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && trig_i && !last_c) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_reset_clear_R7: assert property (@(posedge clk_i)
      $past(rst_i) |-> (!busy_q && cnt_q == '0));

endmodule

// File: rtl/evt_led_stretch.sv
module evt_led_stretch
   import evt_led_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter edge_sel_e   TRIG_EDGE   = EDGE_RISE,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic evt_i,
   output logic led_o
);

   localparam int unsigned PULSE_CYC = half_sec_cycles(CLK_HZ);
   localparam int unsigned CNT_W     = cnt_width(PULSE_CYC);

   if (CLK_HZ < 2) begin : g_bad_clk
      $error("evt_led_stretch: CLK_HZ must be at least 2");
   end

   logic lvl_s;
   logic trig_s;

   evt_sync_chain #(
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (evt_i),
      .sync_o  (lvl_s)
   );

   evt_edge_pick #(
      .EDGE (TRIG_EDGE)
   ) edge_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .lvl_i  (lvl_s),
      .trig_o (trig_s)
   );

   evt_hold_timer #(
      .CYCLES (PULSE_CYC),
      .CNT_W  (CNT_W)
   ) timer_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .trig_i (trig_s),
      .busy_o (led_o)
   );

   assert_reset_low_R7: assert property (@(posedge clk_i)
      $past(rst_i) |-> !led_o);

endmodule

// File: tb/evt_led_stretch_tb_top.sv
`timescale 1ns/1ps
module evt_led_stretch_tb_top;
   import evt_led_pkg::*;

   localparam int unsigned HZ  = 20;
   localparam int          N   = HZ / 2;  // pulse length, R1
   localparam int          LAT = 3;       // SYNC_STAGES + 1, R5

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic led_r, led_f;
   int   n_chk = 0;
   int   n_bad = 0;

   always #2 clk = ~clk;

   evt_led_stretch #(.CLK_HZ(HZ), .TRIG_EDGE(EDGE_RISE), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_i(rst), .evt_i(din), .led_o(led_r));

   evt_led_stretch #(.CLK_HZ(HZ), .TRIG_EDGE(EDGE_FALL), .SYNC_STAGES(2)) dut_fall_i (
      .clk_i(clk), .rst_i(rst), .evt_i(din), .led_o(led_f));

   function automatic logic [63:0] span(input int lo, input int len);
      logic [63:0] m = '0;
      for (int i = lo; i < lo + len; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive pat[c] at falling edge c; led sampled at falling edge c before driving
   task automatic capture(input logic [63:0] pat,
                          output logic [63:0] wr, output logic [63:0] wf);
      for (int c = 0; c < 64; c++) begin
         @(negedge clk);
         wr[c] = led_r;
         wf[c] = led_f;
         din   = pat[c];
      end
   endtask

   initial begin
      logic [63:0] wr, wf, pat;
      repeat (4) @(negedge clk);
      // R7: low during reset
      check("R7", "rise-mode led in reset", {63'd0, led_r}, 64'd0);
      check("R7", "fall-mode led in reset", {63'd0, led_f}, 64'd0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R1 R2 R3 R4 R5: sweep input high widths 1..14 cycles, starting at c=1
      for (int w = 1; w <= 14; w++) begin
         pat = span(1, w);
         capture(pat, wr, wf);
         check("R2/R4/R5", $sformatf("rise width %0d", w), wr, span(1 + LAT, N));
         check("R3/R4/R5", $sformatf("fall width %0d", w), wf, span(1 + w + LAT, N));
      end

      // R6: extra edges inside the pulse are dropped
      pat = 64'd0;
      pat[1] = 1'b1; pat[4] = 1'b1; pat[7] = 1'b1;
      capture(pat, wr, wf);
      check("R6", "rise toggles in pulse", wr, span(1 + LAT, N));
      check("R6", "fall toggles in pulse", wf, span(2 + LAT, N));

      // R6: edge reaching timer on the last high cycle is dropped
      pat = span(1, 2) | span(11, 10);
      capture(pat, wr, wf);
      check("R6", "rise edge on last high cycle", wr, span(4, N));
      check("R3", "fall two pulses", wf, span(6, N) | span(24, N));

      // R8: edge one cycle later starts a new full pulse
      pat = span(1, 2) | span(12, 9);
      capture(pat, wr, wf);
      check("R8", "rise back-to-back", wr, span(4, N) | span(15, N));
      check("R8", "fall two pulses", wf, span(6, N) | span(24, N));

      // R7: reset in mid-pulse abandons it
      @(negedge clk); din = 1'b1;
      @(negedge clk); din = 1'b0;
      repeat (6) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R7", "leds low in mid-pulse reset", {62'd0, led_r, led_f}, 64'd0);
      rst = 1'b0;
      capture(64'd0, wr, wf);
      check("R7", "rise no resume after reset", wr, 64'd0);
      check("R7", "fall no resume after reset", wf, 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule